// File: doc/BRIEF.md
# Asynchronous SRAM cycle controller

This block sits between a clocked host and an external asynchronous static RAM with a 15-bit address, an 8-bit data path and three active-low controls (chip select, write enable, output enable). The host hands over one word at a time through a valid/ready handshake. The controller then plays out a strobe sequence whose every phase is a whole number of system clocks. Each phase length is derived from the memory's nanosecond minimums, rounded up to the next clock period.

A write keeps output enable high for its whole length. The controller drives the bus only after output enable has been high long enough for the memory to release it. The write window is the overlap of chip select and write enable, and both controls close it on the same clock edge. A read holds chip select and output enable low for the access time. The data pins are sampled on the final clock edge of that window, and the byte is handed back with a one-cycle valid pulse. Every access ends with a cycle in which all strobes are high.

The bidirectional data pins are presented as a separate output, output-enable and input, so that the pad ring can build the tristate buffer.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is held and once it is released, `req_ready` is 1, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0 and `rsp_valid` is 0.
- R2: A write opens with TURN_CYC cycles in which chip select is low and write enable and output enable are high. WP_CYC cycles follow with write enable low too. Chip select and write enable then rise on the same edge, and the word stored is the write data.
- R3: Write enable is never low while output enable is low, and output enable stays high for the whole of a write.
- R4: `mem_dq_oe` is 1 only while write enable is low, and only after output enable has been high for at least TURN_CYC consecutive cycles.
- R5: A read holds chip select and output enable low, with write enable high, for exactly RD_CYC cycles, and the address stays stable while chip select is low.
- R6: Read data is sampled on the last clock edge at which output enable is still low. It is presented on `rsp_rdata` with `rsp_valid` high for exactly one cycle, the first cycle after chip select rises.
- R7: After each access there is at least one cycle with all three strobes high. With a request held continuously, chip select stays high for exactly two cycles between accesses.
- R8: `req_ready` is 0 from the cycle after acceptance until the access ends, and a request raised while `req_ready` is 0 is ignored.
- R9: TURN_CYC = max(1, ceil(tOHZ/tCLK)), WP_CYC = max(ceil(tWP/tCLK), ceil(tDW/tCLK)) and RD_CYC = max(ceil(tRC/tCLK), ceil(tAA/tCLK)). At a 10 ns clock with the defaults these are 2, 4 and 6.
- R10: Address and write data are captured when the request is accepted and held for the access, even if the host inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle pulse: read data available |
| rsp_rdata | output | 8 | Read data |
| mem_addr | output | 15 | Memory address pins |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the data pad driver |
| mem_dq_in | input | 8 | Data received from the memory pins |

## Verification
The assertions assume that the host raises `req_valid` only between clock edges and keeps `req_write`, `req_addr` and `req_wdata` steady around the accepting edge. They also assume that the clock period matches the one the cycle parameters were derived for. The bench changes inputs only on falling clock edges and uses the default 10 ns parameters. Its memory model returns data only while chip select and output enable are both low, so read data captured at the wrong edge is caught. The host inputs are deliberately scrambled during busy cycles. This shows that nothing but the accepting edge is sampled.

// File: rtl/sram_cyc_pkg.sv
`timescale 1ns/1ps
package sram_cyc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WSET = 3'd1,
    ST_WPUL = 3'd2,
    ST_RACC = 3'd3,
    ST_GAP  = 3'd4
  } cyc_state_e;

  // whole clock periods covering a time given in picoseconds
  function automatic int cyc_ceil(input int t_ps, input int clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int cyc_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_cyc_timer.sv
`timescale 1ns/1ps
module sram_cyc_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_cyc_seq.sv
`timescale 1ns/1ps
module sram_cyc_seq
  import sram_cyc_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int TURN_CYC = 2,
  parameter int WP_CYC   = 4,
  parameter int RD_CYC   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             expired,
  output logic             accept,
  output logic             capture,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             req_ready,
  output logic             cs_n,
  output logic             we_n,
  output logic             oe_n,
  output logic             dq_oe
);

  localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(TURN_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LD   = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_CYC - 1);

  cyc_state_e st_q, st_d;
  logic cs_n_d, we_n_d, oe_n_d, dq_oe_d, ready_d;

  // next-state and phase timer loading
  always_comb begin
    st_d     = st_q;
    accept   = 1'b0;
    capture  = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept   = 1'b1;
          tmr_load = 1'b1;
          if (req_write) begin
            st_d    = ST_WSET;
            tmr_val = TURN_LD;
          end else begin
            st_d    = ST_RACC;
            tmr_val = RD_LD;
          end
        end
      end
      ST_WSET: begin
        if (expired) begin
          st_d     = ST_WPUL;
          tmr_load = 1'b1;
          tmr_val  = WP_LD;
        end
      end
      ST_WPUL: if (expired) st_d = ST_GAP;
      ST_RACC: begin
        if (expired) begin
          st_d    = ST_GAP;
          capture = 1'b1;
        end
      end
      ST_GAP:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // strobes decoded from the next state so the pins come straight from flops
  always_comb begin
    cs_n_d  = !((st_d == ST_WSET) || (st_d == ST_WPUL) || (st_d == ST_RACC));
    we_n_d  = (st_d != ST_WPUL);
    oe_n_d  = (st_d != ST_RACC);
    dq_oe_d = (st_d == ST_WPUL);
    ready_d = (st_d == ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cs_n      <= 1'b1;
      we_n      <= 1'b1;
      oe_n      <= 1'b1;
      dq_oe     <= 1'b0;
      req_ready <= 1'b1;
    end else begin
      st_q      <= st_d;
      cs_n      <= cs_n_d;
      we_n      <= we_n_d;
      oe_n      <= oe_n_d;
      dq_oe     <= dq_oe_d;
      req_ready <= ready_d;
    end
  end

endmodule

// File: rtl/sram_cyc_dpath.sv
`timescale 1ns/1ps
module sram_cyc_dpath #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] wdat_d, rdat_d;

  always_comb begin
    addr_d = accept  ? req_addr  : mem_addr;
    wdat_d = accept  ? req_wdata : mem_dq_out;
    rdat_d = capture ? mem_dq_in : rsp_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rsp_rdata  <= '0;
      rsp_valid  <= 1'b0;
    end else begin
      mem_addr   <= addr_d;
      mem_dq_out <= wdat_d;
      rsp_rdata  <= rdat_d;
      rsp_valid  <= capture;
    end
  end

endmodule

// File: rtl/sram_cycle_ctrl.sv
`timescale 1ns/1ps
module sram_cycle_ctrl
  import sram_cyc_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int CLK_PS = 10000,
  parameter int WP_PS  = 40000,
  parameter int DW_PS  = 30000,
  parameter int OHZ_PS = 20000,
  parameter int RC_PS  = 55000,
  parameter int AA_PS  = 55000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int TURN_CYC = cyc_max(1, cyc_ceil(OHZ_PS, CLK_PS));
  localparam int WP_CYC   = cyc_max(cyc_ceil(WP_PS, CLK_PS), cyc_ceil(DW_PS, CLK_PS));
  localparam int RD_CYC   = cyc_max(cyc_ceil(RC_PS, CLK_PS), cyc_ceil(AA_PS, CLK_PS));
  localparam int MAX_CYC  = cyc_max(TURN_CYC, cyc_max(WP_CYC, RD_CYC));
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  // reset asserts at once, leaves on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic             accept, capture, tmr_load, expired;
  logic [CNT_W-1:0] tmr_val;

  sram_cyc_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (expired)
  );

  sram_cyc_seq #(
    .CNT_W    (CNT_W),
    .TURN_CYC (TURN_CYC),
    .WP_CYC   (WP_CYC),
    .RD_CYC   (RD_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .expired   (expired),
    .accept    (accept),
    .capture   (capture),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .req_ready (req_ready),
    .cs_n      (mem_cs_n),
    .we_n      (mem_we_n),
    .oe_n      (mem_oe_n),
    .dq_oe     (mem_dq_oe)
  );

  sram_cyc_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .accept     (accept),
    .capture    (capture),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

endmodule

// File: rtl/sram_cyc_chk.sv
`timescale 1ns/1ps
module sram_cyc_chk #(
  parameter int ADDR_W   = 15,
  parameter int TURN_CYC = 2,
  parameter int WP_CYC   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe,
  input logic [ADDR_W-1:0] mem_addr
);

  int unsigned oe_hi_cnt;
  int unsigned we_lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_hi_cnt <= 0;
      we_lo_cnt <= 0;
    end else begin
      if (!mem_oe_n)                     oe_hi_cnt <= 0;
      else if (oe_hi_cnt < TURN_CYC + 1) oe_hi_cnt <= oe_hi_cnt + 1;
      if (mem_we_n)                      we_lo_cnt <= 0;
      else if (we_lo_cnt < WP_CYC + 1)   we_lo_cnt <= we_lo_cnt + 1;
    end
  end

  // R3
  no_we_with_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_oe_n));

  // R2
  write_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_lo_cnt >= WP_CYC) && mem_cs_n);

  // R4
  drive_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n && mem_oe_n && oe_hi_cnt >= TURN_CYC));

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

  // R6
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R7
  idle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cs_n) |-> (mem_we_n && mem_oe_n));

  // R8
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> !req_ready);

endmodule

bind sram_cycle_ctrl sram_cyc_chk #(
  .ADDR_W   (ADDR_W),
  .TURN_CYC (TURN_CYC),
  .WP_CYC   (WP_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_cs_n  (mem_cs_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_dq_oe (mem_dq_oe),
  .mem_addr  (mem_addr)
);

// File: tb/sram_cycle_ctrl_bench.sv
`timescale 1ns/1ps
module sram_cycle_ctrl_bench;

  // R9: cycle counts expected at a 10 ns clock
  localparam int TCLK    = 10;
  localparam int TB_TURN = (20 + TCLK - 1) / TCLK;
  localparam int TB_WP   = (40 + TCLK - 1) / TCLK;
  localparam int TB_RD   = (55 + TCLK - 1) / TCLK;

  localparam logic [3:0] S_IDLE = 4'b1110;  // {cs_n, we_n, oe_n, dq_oe}
  localparam logic [3:0] S_WSET = 4'b0110;
  localparam logic [3:0] S_WPUL = 4'b0011;
  localparam logic [3:0] S_READ = 4'b0100;

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_write;
  logic [14:0] req_addr, mem_addr;
  logic [7:0]  req_wdata, rsp_rdata, mem_dq_out, mem_dq_in;
  logic        rsp_valid, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;

  int  n_chk, n_bad;
  bit  tb_done;
  logic [7:0] model [256];

  sram_cycle_ctrl u_sram_cycle_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // memory model: stores on clock edges inside the write window, drives only when read-enabled
  always @(posedge clk)
    if (!mem_cs_n && !mem_we_n && mem_dq_oe) model[mem_addr[7:0]] <= mem_dq_out;
  assign mem_dq_in = (!mem_cs_n && !mem_oe_n) ? model[mem_addr[7:0]] : 8'h5A;

  function automatic logic [3:0] strobes();
    return {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wait_ready();
    while (!req_ready) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk(strobes() == S_IDLE, "R1 strobes in reset", strobes(), S_IDLE);
    chk(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(strobes() == S_IDLE && !rsp_valid, "R1 after release", {rsp_valid, strobes()}, S_IDLE);
    chk(req_ready == 1'b1, "R1 ready after release", req_ready, 1);
  endtask

  task automatic t_write(input logic [14:0] a, input logic [7:0] d);
    wait_ready();
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;  // R10 scramble
    for (int i = 0; i < TB_TURN; i++) begin
      chk(strobes() == S_WSET, "R2 setup phase", strobes(), S_WSET);
      chk(!req_ready, "R8 ready low in write", req_ready, 0);
      @(negedge clk);
    end
    for (int i = 0; i < TB_WP; i++) begin
      chk(strobes() == S_WPUL, "R4 pulse phase", strobes(), S_WPUL);
      chk(mem_dq_out == d && mem_addr == a, "R10 held write data",
          {mem_addr, mem_dq_out}, {a, d});
      @(negedge clk);
    end
    chk(strobes() == S_IDLE, "R7 idle after write", strobes(), S_IDLE);
    chk(!req_ready, "R8 ready low in gap", req_ready, 0);
    @(negedge clk);
    chk(req_ready, "R8 ready back", req_ready, 1);
  endtask

  task automatic t_read(input logic [14:0] a, input logic [7:0] exp);
    wait_ready();
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a;
    for (int i = 0; i < TB_RD; i++) begin
      chk(strobes() == S_READ, "R5 read phase", strobes(), S_READ);
      chk(mem_addr == a, "R5 read address", mem_addr, a);
      chk(!rsp_valid, "R6 no early valid", rsp_valid, 0);
      @(negedge clk);
    end
    chk(strobes() == S_IDLE, "R7 idle after read", strobes(), S_IDLE);
    chk(rsp_valid && rsp_rdata == exp, "R6 read data", {rsp_valid, rsp_rdata}, {1'b1, exp});
    @(negedge clk);
    chk(!rsp_valid, "R6 single pulse", rsp_valid, 0);
    chk(req_ready, "R8 ready after read", req_ready, 1);
  endtask

  task automatic t_ignore();
    wait_ready();
    req_valid = 1'b1; req_write = 1'b1; req_addr = 15'h0011; req_wdata = 8'h77;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 15'h0022; req_wdata = 8'h99;
    @(negedge clk);
    req_valid = 1'b0;
    wait_ready();
    for (int i = 0; i < 4; i++) begin
      chk(mem_cs_n, "R8 busy request ignored", mem_cs_n, 1);
      @(negedge clk);
    end
    t_read(15'h0022, 8'h00);
    t_read(15'h0011, 8'h77);
  endtask

  task automatic t_back2back();
    int low_cnt;
    int high_cnt;
    wait_ready();
    req_valid = 1'b1; req_write = 1'b0; req_addr = 15'h7FFF;
    while (mem_cs_n) @(negedge clk);
    low_cnt = 0;
    while (!mem_cs_n) begin low_cnt++; @(negedge clk); end
    high_cnt = 0;
    while (mem_cs_n && high_cnt < 10) begin high_cnt++; @(negedge clk); end
    req_valid = 1'b0;
    chk(low_cnt == TB_RD, "R9 read length", low_cnt, TB_RD);
    chk(high_cnt == 2, "R7 gap between held requests", high_cnt, 2);
    wait_ready();
    @(negedge clk);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; tb_done = 1'b0;
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    t_reset();
    t_write(15'h0000, 8'hA5);
    t_write(15'h7FFF, 8'h3C);
    t_write(15'h1234, 8'hFF);
    t_write(15'h00AB, 8'h00);
    t_read(15'h0000, 8'hA5);
    t_read(15'h7FFF, 8'h3C);
    t_read(15'h1234, 8'hFF);
    t_read(15'h00AB, 8'h00);
    t_write(15'h1234, 8'h5B);
    t_read(15'h1234, 8'h5B);
    t_ignore();
    t_back2back();
    tb_done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!tb_done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule